// File: doc/BRIEF.md
# Execute-Stage Operand Register Files

This block holds two tiny register files inside the execute stage, each tied to one function unit. The address file belongs to the load/store unit and the data file belongs to the ALU. Each file keeps four 32-bit words that live only briefly. They are staged right beside the unit that consumes them, so most operand reads never reach the large shared register file.

Either unit's execute result may be written into any entry of either file. Each file therefore takes two writes per cycle, one from each unit. Each file also has two read ports, and only its owning unit may use them. The read happens in the execute stage, alongside operand forwarding. Each read port carries a combined source selector. A 6-bit specifier either names an operand register directly, or names a general register. For a general register, a 2-bit forwarding code then picks the decoded value, the load/store execute result, the ALU execute result or the write-back result. Operand registers and general registers are addressed directly by instructions, and no value is copied between the two levels.

Top module: `exec_operand_store`

## Requirements
- R1: After an asynchronous active-low reset, every entry of both files reads as zero.
- R2: A write with enable high, file select f (0 = address file, 1 = data file) and entry index i stores that unit's execute result. The new value is read from the next cycle on. Writes from the two units to different entries of one file in the same cycle both take effect.
- R3: When both units write the same entry of the same file in one cycle, the ALU value is stored. The conflict bit for that file is high during that cycle only, and it stays low for writes to different entries or different files.
- R4: A read of an entry that is being written in the same cycle returns the value that will be stored (write-through), including the ALU value when the two writes collide.
- R5: File 0 is owned by unit id 0 (load/store) and file 1 by unit id 1 (ALU). An enabled read whose requester id differs from the owner returns zero data with the error bit high, and it leaves the file contents unchanged.
- R6: A read port whose enable is low returns zero data with the error bit low.
- R7: For specifiers 0 to 31, forwarding code 0 returns the decoded general-register value, 1 the load/store execute result, 2 the ALU execute result and 3 the write-back result.
- R8: Specifiers 32 to 35 return entries 0 to 3 of the port's own file, whatever the forwarding code.
- R9: Specifiers 36 to 63 are reserved and return zero data with the error bit low.
- R10: A write whose enable is low changes nothing. A write to one file never alters the other file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsu_wr_en | input | 1 | Load/store result write enable |
| lsu_wr_file | input | 1 | Target file of the load/store write |
| lsu_wr_idx | input | 2 | Target entry of the load/store write |
| lsu_ex_res | input | 32 | Load/store execute result (write data and forward source) |
| alu_wr_en | input | 1 | ALU result write enable |
| alu_wr_file | input | 1 | Target file of the ALU write |
| alu_wr_idx | input | 2 | Target entry of the ALU write |
| alu_ex_res | input | 32 | ALU execute result (write data and forward source) |
| wb_res | input | 32 | Write-back stage result for forwarding |
| rd_en | input | 2x2 | Read enable per file and port |
| rd_fu | input | 2x2 | Requester unit id per file and port |
| rd_spec | input | 2x2x6 | Register specifier per file and port |
| rd_gr | input | 2x2x32 | Decoded general-register value per file and port |
| rd_fwd | input | 2x2x2 | Forwarding code per file and port |
| rd_data | output | 2x2x32 | Selected operand per file and port |
| rd_err | output | 2x2 | Non-owner read error per file and port |
| wr_conflict | output | 2 | Same-entry write collision per file |

## Verification
A corrupted entry shows up on the first owner read of that entry after the faulty write, through specifier 32 plus the index. It shows the same cycle if the read overlaps the write, because of the write-through path. A wrong collision winner or a wrong file decode leaves a value visible one cycle later on either file's read ports. A broken ownership or source decode shows up combinationally on the same cycle, in rd_data and rd_err. The bench sweeps every specifier and forwarding code on every port, and it reads back every entry after each group of writes.

// File: rtl/opstage_pkg.sv
package opstage_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_OR  = 4;
  localparam int SPEC_W  = 6;
  localparam int OR_BASE = 32;
  localparam int NUM_RP  = 2;

  typedef enum logic [0:0] {
    FU_LSU = 1'b0,
    FU_ALU = 1'b1
  } fu_id_e;

  typedef enum logic [1:0] {
    SRC_GR     = 2'd0,
    SRC_LSU_EX = 2'd1,
    SRC_ALU_EX = 2'd2,
    SRC_WB     = 2'd3
  } fwd_sel_e;
endpackage

// File: rtl/orf_storage.sv
module orf_storage #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  we,      // [0] load/store, [1] ALU
  input  logic [1:0][IDX_W-1:0]       widx,
  input  logic [1:0][W-1:0]           wdata,
  output logic [DEPTH-1:0][W-1:0]     q,
  output logic [DEPTH-1:0][W-1:0]     nxt,     // value after this cycle's writes
  output logic                        conflict
);
  logic [DEPTH-1:0][W-1:0] q_r;
  logic [DEPTH-1:0]        ent_en;

  // next-state: ALU port wins a same-entry collision
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      ent_en[e] = (we[0] && (widx[0] == IDX_W'(e))) ||
                  (we[1] && (widx[1] == IDX_W'(e)));
      if (we[1] && (widx[1] == IDX_W'(e)))
        nxt[e] = wdata[1];
      else if (we[0] && (widx[0] == IDX_W'(e)))
        nxt[e] = wdata[0];
      else
        nxt[e] = q_r[e];
    end
  end

  assign conflict = we[0] && we[1] && (widx[0] == widx[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (ent_en[e]) q_r[e] <= nxt[e];
      end
    end
  end

  assign q = q_r;

  // R3: on a collision the ALU value is what remains stored
  a_r3_alu_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we[0] && we[1] && (widx[0] == widx[1])) |=> (q_r[$past(widx[1])] == $past(wdata[1])));

  // R10: no write enable, no change to any entry
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (we == 2'b00) |=> $stable(q_r));

  // R2: a lone load/store write lands in its entry
  a_r2_lsu_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we == 2'b01) |=> (q_r[$past(widx[0])] == $past(wdata[0])));
endmodule

// File: rtl/orf_read_port.sv
module orf_read_port
  import opstage_pkg::*;
#(
  parameter int   W       = 32,
  parameter int   DEPTH   = 4,
  parameter int   SPEC_W  = 6,
  parameter int   OR_BASE = 32,
  parameter logic OWNER   = 1'b0,
  localparam int  IDX_W   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    fu,
  input  logic [SPEC_W-1:0]       spec,
  input  logic [W-1:0]            gr,
  input  logic [1:0]              fwd,
  input  logic [W-1:0]            lsu_ex,
  input  logic [W-1:0]            alu_ex,
  input  logic [W-1:0]            wb,
  input  logic [DEPTH-1:0][W-1:0] view,
  output logic [W-1:0]            data,
  output logic                    err
);
  localparam logic [SPEC_W:0]   BASE_X = (SPEC_W+1)'(OR_BASE);
  localparam logic [SPEC_W:0]   TOP_X  = (SPEC_W+1)'(OR_BASE + DEPTH);
  localparam logic [SPEC_W-1:0] BASE_V = SPEC_W'(OR_BASE);

  logic [SPEC_W:0]  spec_x;
  logic             is_gr;
  logic             is_or;
  logic [IDX_W-1:0] idx;

  assign spec_x = {1'b0, spec};
  assign is_gr  = spec_x < BASE_X;
  assign is_or  = (spec_x >= BASE_X) && (spec_x < TOP_X);
  assign idx    = IDX_W'(spec - BASE_V);

  always_comb begin
    data = '0;
    err  = 1'b0;
    if (en) begin
      if (fu != OWNER) begin
        err = 1'b1;
      end else if (is_or) begin
        data = view[idx];
      end else if (is_gr) begin
        case (fwd)
          SRC_LSU_EX: data = lsu_ex;
          SRC_ALU_EX: data = alu_ex;
          SRC_WB:     data = wb;
          default:    data = gr;
        endcase
      end
    end
  end

  // R6: an idle port is quiet
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (data == '0 && !err));

  // R5: foreign requester sees an error and no data
  a_r5_foreign_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fu != OWNER) |-> (err && data == '0));

  // R9: reserved specifiers carry no data
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fu == OWNER && spec_x >= TOP_X) |-> (data == '0 && !err));
endmodule

// File: rtl/orf_bank.sv
module orf_bank #(
  parameter int   W       = 32,
  parameter int   DEPTH   = 4,
  parameter int   SPEC_W  = 6,
  parameter int   OR_BASE = 32,
  parameter int   NUM_RP  = 2,
  parameter logic OWNER   = 1'b0,
  localparam int  IDX_W   = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     we,
  input  logic [1:0][IDX_W-1:0]          widx,
  input  logic [1:0][W-1:0]              wdata,
  input  logic [W-1:0]                   wb,
  input  logic [NUM_RP-1:0]              rd_en,
  input  logic [NUM_RP-1:0]              rd_fu,
  input  logic [NUM_RP-1:0][SPEC_W-1:0]  rd_spec,
  input  logic [NUM_RP-1:0][W-1:0]       rd_gr,
  input  logic [NUM_RP-1:0][1:0]         rd_fwd,
  output logic [NUM_RP-1:0][W-1:0]       rd_data,
  output logic [NUM_RP-1:0]              rd_err,
  output logic                           conflict
);
  logic [DEPTH-1:0][W-1:0] q;
  logic [DEPTH-1:0][W-1:0] nxt;

  orf_storage #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (we),
    .widx     (widx),
    .wdata    (wdata),
    .q        (q),
    .nxt      (nxt),
    .conflict (conflict)
  );

  for (genvar p = 0; p < NUM_RP; p++) begin : g_port
    orf_read_port #(
      .W(W), .DEPTH(DEPTH), .SPEC_W(SPEC_W), .OR_BASE(OR_BASE), .OWNER(OWNER)
    ) u_rp (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (rd_en[p]),
      .fu     (rd_fu[p]),
      .spec   (rd_spec[p]),
      .gr     (rd_gr[p]),
      .fwd    (rd_fwd[p]),
      .lsu_ex (wdata[0]),
      .alu_ex (wdata[1]),
      .wb     (wb),
      .view   (nxt),
      .data   (rd_data[p]),
      .err    (rd_err[p])
    );

    // R4: a same-cycle ALU write to the read entry is seen at once
    a_r4_bypass_alu: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[p] && rd_fu[p] == OWNER && we[1] &&
       rd_spec[p] == SPEC_W'(OR_BASE + int'(widx[1])))
      |-> (rd_data[p] == wdata[1]));

    // R8: an operand-register read shows the stored entry when nothing writes
    a_r8_or_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[p] && rd_fu[p] == OWNER && we == 2'b00 &&
       rd_spec[p] >= SPEC_W'(OR_BASE) && rd_spec[p] < SPEC_W'(OR_BASE + DEPTH))
      |-> (rd_data[p] == q[IDX_W'(rd_spec[p] - SPEC_W'(OR_BASE))]));
  end
endmodule

// File: rtl/exec_operand_store.sv
module exec_operand_store
  import opstage_pkg::*;
#(
  parameter int WORD_W_P  = WORD_W,
  parameter int NUM_OR_P  = NUM_OR,
  parameter int SPEC_W_P  = SPEC_W,
  parameter int OR_BASE_P = OR_BASE,
  parameter int NUM_RP_P  = NUM_RP,
  localparam int NUM_FILES = 2,
  localparam int IDX_W     = $clog2(NUM_OR_P)
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              lsu_wr_en,
  input  logic                                              lsu_wr_file,
  input  logic [IDX_W-1:0]                                  lsu_wr_idx,
  input  logic [WORD_W_P-1:0]                               lsu_ex_res,
  input  logic                                              alu_wr_en,
  input  logic                                              alu_wr_file,
  input  logic [IDX_W-1:0]                                  alu_wr_idx,
  input  logic [WORD_W_P-1:0]                               alu_ex_res,
  input  logic [WORD_W_P-1:0]                               wb_res,
  input  logic [NUM_FILES-1:0][NUM_RP_P-1:0]                rd_en,
  input  logic [NUM_FILES-1:0][NUM_RP_P-1:0]                rd_fu,
  input  logic [NUM_FILES-1:0][NUM_RP_P-1:0][SPEC_W_P-1:0]  rd_spec,
  input  logic [NUM_FILES-1:0][NUM_RP_P-1:0][WORD_W_P-1:0]  rd_gr,
  input  logic [NUM_FILES-1:0][NUM_RP_P-1:0][1:0]           rd_fwd,
  output logic [NUM_FILES-1:0][NUM_RP_P-1:0][WORD_W_P-1:0]  rd_data,
  output logic [NUM_FILES-1:0][NUM_RP_P-1:0]                rd_err,
  output logic [NUM_FILES-1:0]                              wr_conflict
);
  logic [1:0][IDX_W-1:0]    widx;
  logic [1:0][WORD_W_P-1:0] wdata;

  assign widx  = {alu_wr_idx, lsu_wr_idx};
  assign wdata = {alu_ex_res, lsu_ex_res};

  // file 0 = address file (owner load/store), file 1 = data file (owner ALU)
  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    logic [1:0] we_f;
    assign we_f[0] = lsu_wr_en && (lsu_wr_file == 1'(f));
    assign we_f[1] = alu_wr_en && (alu_wr_file == 1'(f));

    orf_bank #(
      .W(WORD_W_P), .DEPTH(NUM_OR_P), .SPEC_W(SPEC_W_P), .OR_BASE(OR_BASE_P),
      .NUM_RP(NUM_RP_P), .OWNER(1'(f))
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we_f),
      .widx     (widx),
      .wdata    (wdata),
      .wb       (wb_res),
      .rd_en    (rd_en[f]),
      .rd_fu    (rd_fu[f]),
      .rd_spec  (rd_spec[f]),
      .rd_gr    (rd_gr[f]),
      .rd_fwd   (rd_fwd[f]),
      .rd_data  (rd_data[f]),
      .rd_err   (rd_err[f]),
      .conflict (wr_conflict[f])
    );

    // R3: a collision flag needs both units aimed at this file
    a_r3_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      wr_conflict[f] |-> (lsu_wr_en && alu_wr_en &&
                          lsu_wr_file == 1'(f) && alu_wr_file == 1'(f) &&
                          lsu_wr_idx == alu_wr_idx));
  end
endmodule

// File: tb/tb_exec_operand_store.sv
module tb_exec_operand_store;
  logic clk = 1'b0;
  logic rst_n;
  logic        lsu_wr_en, lsu_wr_file, alu_wr_en, alu_wr_file;
  logic [1:0]  lsu_wr_idx, alu_wr_idx;
  logic [31:0] lsu_ex_res, alu_ex_res, wb_res;
  logic [1:0][1:0]        rd_en, rd_fu, rd_err;
  logic [1:0][1:0][5:0]   rd_spec;
  logic [1:0][1:0][31:0]  rd_gr, rd_data;
  logic [1:0][1:0][1:0]   rd_fwd;
  logic [1:0]             wr_conflict;

  logic [31:0] mdl [2][4];
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  exec_operand_store dut (
    .clk(clk), .rst_n(rst_n),
    .lsu_wr_en(lsu_wr_en), .lsu_wr_file(lsu_wr_file), .lsu_wr_idx(lsu_wr_idx),
    .lsu_ex_res(lsu_ex_res),
    .alu_wr_en(alu_wr_en), .alu_wr_file(alu_wr_file), .alu_wr_idx(alu_wr_idx),
    .alu_ex_res(alu_ex_res), .wb_res(wb_res),
    .rd_en(rd_en), .rd_fu(rd_fu), .rd_spec(rd_spec), .rd_gr(rd_gr),
    .rd_fwd(rd_fwd), .rd_data(rd_data), .rd_err(rd_err),
    .wr_conflict(wr_conflict)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic no_writes();
    lsu_wr_en = 1'b0; alu_wr_en = 1'b0;
  endtask

  task automatic owner_read(input int f, input int p, input int i);
    rd_en[f][p] = 1'b1; rd_fu[f][p] = 1'(f);
    rd_spec[f][p] = 6'(32 + i); rd_fwd[f][p] = 2'(3 - i);
  endtask

  task automatic check_all(input string tag);
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 4; i++)
        for (int p = 0; p < 2; p++) begin
          owner_read(f, p, i);
          #1;
          check(tag, rd_data[f][p], mdl[f][i]);
        end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    no_writes();
    lsu_wr_file = 0; alu_wr_file = 0; lsu_wr_idx = 0; alu_wr_idx = 0;
    lsu_ex_res = 32'h0; alu_ex_res = 32'h0; wb_res = 32'h0;
    rd_en = '0; rd_fu = '0; rd_spec = '0; rd_gr = '0; rd_fwd = '0;
    for (int f = 0; f < 2; f++) for (int i = 0; i < 4; i++) mdl[f][i] = 32'h0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    cyc();

    // R1: reset state
    check_all("R1 reset entry");
    check("R1 conflict idle", 32'(wr_conflict), 32'h0);

    // R2 / R10: every writer into every entry of every file
    for (int f = 0; f < 2; f++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 4; i++) begin
          logic [31:0] v;
          v = 32'hA500_0000 + 32'(f * 4096 + w * 256 + i * 17);
          if (w == 0) begin
            lsu_wr_en = 1'b1; lsu_wr_file = 1'(f); lsu_wr_idx = 2'(i); lsu_ex_res = v;
          end else begin
            alu_wr_en = 1'b1; alu_wr_file = 1'(f); alu_wr_idx = 2'(i); alu_ex_res = v;
          end
          cyc();
          no_writes();
          mdl[f][i] = v;
          check_all("R2 R10 single write readback");
        end

    // R2 / R3: two writes into different entries of one file
    for (int f = 0; f < 2; f++) begin
      lsu_wr_en = 1; lsu_wr_file = 1'(f); lsu_wr_idx = 2'd1; lsu_ex_res = 32'h1357_0000 + 32'(f);
      alu_wr_en = 1; alu_wr_file = 1'(f); alu_wr_idx = 2'd2; alu_ex_res = 32'h2468_0000 + 32'(f);
      #3 check("R3 no conflict different entries", 32'(wr_conflict), 32'h0);
      cyc();
      no_writes();
      mdl[f][1] = 32'h1357_0000 + 32'(f);
      mdl[f][2] = 32'h2468_0000 + 32'(f);
      check_all("R2 dual write");
    end

    // R3: same entry, different files -> no conflict
    lsu_wr_en = 1; lsu_wr_file = 0; lsu_wr_idx = 2'd3; lsu_ex_res = 32'h0F0F_0001;
    alu_wr_en = 1; alu_wr_file = 1; alu_wr_idx = 2'd3; alu_ex_res = 32'hF0F0_0002;
    #3 check("R3 no conflict across files", 32'(wr_conflict), 32'h0);
    cyc();
    no_writes();
    mdl[0][3] = 32'h0F0F_0001; mdl[1][3] = 32'hF0F0_0002;
    check_all("R10 cross-file isolation");

    // R3 / R4: collision on every entry of each file
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 4; i++) begin
        logic [31:0] la, aa;
        la = 32'h7000_0000 + 32'(f * 16 + i);
        aa = 32'h8000_0000 + 32'(f * 16 + i);
        lsu_wr_en = 1; lsu_wr_file = 1'(f); lsu_wr_idx = 2'(i); lsu_ex_res = la;
        alu_wr_en = 1; alu_wr_file = 1'(f); alu_wr_idx = 2'(i); alu_ex_res = aa;
        owner_read(f, 0, i);
        #3;
        check("R3 conflict flag high", 32'(wr_conflict), 32'(1 << f));
        check("R4 bypass collision winner", rd_data[f][0], aa);
        cyc();
        no_writes();
        mdl[f][i] = aa;
        #1 check("R3 conflict flag drops", 32'(wr_conflict), 32'h0);
        check_all("R3 alu wins stored");
      end

    // R4: single-writer bypass, neighbour entry shows old value
    for (int f = 0; f < 2; f++) begin
      lsu_wr_en = 1; lsu_wr_file = 1'(f); lsu_wr_idx = 2'd0; lsu_ex_res = 32'hBEEF_0000 + 32'(f);
      owner_read(f, 0, 0);
      owner_read(f, 1, 1);
      #3;
      check("R4 bypass new value", rd_data[f][0], 32'hBEEF_0000 + 32'(f));
      check("R4 other entry old", rd_data[f][1], mdl[f][1]);
      cyc();
      no_writes();
      mdl[f][0] = 32'hBEEF_0000 + 32'(f);
    end

    // R5: foreign requester on every OR specifier and port
    for (int f = 0; f < 2; f++)
      for (int p = 0; p < 2; p++)
        for (int i = 0; i < 4; i++) begin
          rd_en[f][p] = 1; rd_fu[f][p] = 1'(1 - f); rd_spec[f][p] = 6'(32 + i); rd_fwd[f][p] = 0;
          #1;
          check("R5 foreign data zero", rd_data[f][p], 32'h0);
          check("R5 foreign error", 32'(rd_err[f][p]), 32'h1);
        end
    cyc();
    check_all("R5 contents unchanged");

    // R6: disabled ports
    for (int f = 0; f < 2; f++)
      for (int p = 0; p < 2; p++) begin
        rd_en[f][p] = 0; rd_fu[f][p] = 1'(1 - f); rd_spec[f][p] = 6'd33; rd_gr[f][p] = 32'hFFFF_FFFF;
        #1;
        check("R6 idle data", rd_data[f][p], 32'h0);
        check("R6 idle error", 32'(rd_err[f][p]), 32'h0);
      end

    // R7 / R8 / R9: full specifier x forwarding sweep
    lsu_ex_res = 32'h1111_AAAA; alu_ex_res = 32'h2222_BBBB; wb_res = 32'h3333_CCCC;
    for (int f = 0; f < 2; f++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 64; s++)
          for (int c = 0; c < 4; c++) begin
            logic [31:0] g, e;
            g = 32'h4000_0000 + 32'(f * 100000 + p * 1000 + s * 7 + c);
            rd_en[f][p] = 1; rd_fu[f][p] = 1'(f); rd_spec[f][p] = 6'(s);
            rd_gr[f][p] = g; rd_fwd[f][p] = 2'(c);
            if (s < 32) e = (c == 0) ? g : (c == 1) ? lsu_ex_res : (c == 2) ? alu_ex_res : wb_res;
            else if (s < 36) e = mdl[f][s - 32];
            else e = 32'h0;
            #1;
            if (s < 32) check("R7 source select", rd_data[f][p], e);
            else if (s < 36) check("R8 operand register", rd_data[f][p], e);
            else check("R9 reserved", rd_data[f][p], e);
            if (s >= 32) check("R9 R8 no error", 32'(rd_err[f][p]), 32'h0);
          end

    // R10: disabled writes with live index/data do nothing
    lsu_wr_en = 0; lsu_wr_file = 1; lsu_wr_idx = 2; lsu_ex_res = 32'hDEAD_DEAD;
    alu_wr_en = 0; alu_wr_file = 0; alu_wr_idx = 1; alu_ex_res = 32'hCAFE_CAFE;
    cyc();
    cyc();
    check_all("R10 disabled write");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule